// File: doc/BRIEF.md
# Encoded PIO Strobe Timing Generator

This block produces the read and write strobes for one programmed-I/O access on a parallel disk interface. Each access runs three phases in a fixed order: address setup, the active strobe, then hold and recovery. The length of each phase, in bus clocks, is taken from an 8-bit timing byte. The byte is not a raw count. Each of its three fields is a small code that a fixed, non-linear scale turns into a clock count.

Two timing bytes are presented at all times. One serves data-port accesses and the other serves command and control-port accesses. A per-access port flag picks one of them. When the controller is idle, a start request captures the chosen byte, the port flag and the read/write direction. From then on the access runs to completion on its own.

When the ready-handshake enable is set, a low ready pin stretches the active phase. The controller asserts busy for the whole access and pulses done on its final clock.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, the rd_strobe_o, wr_strobe_o, busy_o and done_o outputs are all low.
- R2: Bits 7..6 of the selected timing byte set the setup length. Codes 0, 1, 2 and 3 give 1, 2, 3 and 4 clocks, during which busy is high and both strobes are low.
- R3: Bits 5..3 set the hold length. Codes 0 through 7 give 1, 2, 3, 4, 5, 6, 8 and 12 clocks of busy with both strobes low after the strobe.
- R4: Bits 2..0 set the active length. Codes 0 through 7 give 2, 3, 4, 5, 6, 8, 12 and 16 clocks of strobe.
- R5: With cmd_port_i low, the data timing byte is used. With cmd_port_i high, the command timing byte is used. The byte 0x00 gives the shortest access, 4 clocks in all.
- R6: A read (write_i low) drives only rd_strobe_o and a write (write_i high) drives only wr_strobe_o. A strobe is high only in the active phase, and the two strobes are never high together.
- R7: busy_o rises in the clock after an accepted start and stays high until done_o. done_o is a one-clock pulse on the last hold clock, and busy_o is low in the following clock.
- R8: While iordy_en_i is high and iordy_i is low, the strobe is held at its last active clock. It is released by the first clock edge that samples iordy_i high.
- R9: While iordy_en_i is low, the level of iordy_i has no effect on any phase length.
- R10: A start request made while busy_o is high is ignored. It neither changes the running access nor starts another after it.
- R11: The timing bytes, the port flag and the direction are captured when a start is accepted. Later changes to them have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one access (taken only when idle) |
| write_i | input | 1 | 1 = write access, 0 = read access |
| cmd_port_i | input | 1 | 1 = command/control port, 0 = data port |
| data_timing_i | input | 8 | Encoded timing byte for data-port accesses |
| cmd_timing_i | input | 8 | Encoded timing byte for command-port accesses |
| iordy_en_i | input | 1 | Enables ready-pin stretching of the strobe |
| iordy_i | input | 1 | Device ready pin |
| rd_strobe_o | output | 1 | Read strobe, active high |
| wr_strobe_o | output | 1 | Write strobe, active high |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock pulse on the last hold clock |

## Verification
The bench sweeps timing bytes so that every code of every field occurs at least once. This catches a decode that treats the upper hold and active codes as linear: codes 6 and 7 would then come out 1 or more clocks short. It also checks the counts at a field's first and last code, where a design that loads N rather than N-1 into its phase counter would show one extra clock in every phase.

The ready pin is held low both with the enable on and with it off. A design that ignores the enable, or samples the pin outside the last active clock, shows a strobe that is too long or too short. The bench also raises a second start in the middle of an access and changes the timing bytes at the same time. A design that queues the request would show busy again after done, and one that reads the bytes live would show wrong phase lengths.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  // Width of one encoded timing byte and of a decoded phase length.
  localparam int TB_W  = 8;
  localparam int LEN_W = 5;

  // Field positions within the timing byte (fixed by the encoding).
  localparam int SU_LSB  = 6;
  localparam int SU_W    = 2;
  localparam int HLD_LSB = 3;
  localparam int HLD_W   = 3;
  localparam int ACT_LSB = 0;
  localparam int ACT_W   = 3;

  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    len_t setup;
    len_t active;
    len_t hold;
  } timing_t;

  // Setup: linear, code + 1.
  function automatic len_t su_clocks(input logic [SU_W-1:0] code);
    return len_t'(code) + len_t'(1);
  endfunction

  // Hold: linear up to 6, then 8 and 12.
  function automatic len_t hld_clocks(input logic [HLD_W-1:0] code);
    len_t r;
    case (code)
      3'd6:    r = len_t'(8);
      3'd7:    r = len_t'(12);
      default: r = len_t'(code) + len_t'(1);
    endcase
    return r;
  endfunction

  // Active: linear 2..6, then 8, 12, 16.
  function automatic len_t act_clocks(input logic [ACT_W-1:0] code);
    len_t r;
    case (code)
      3'd5:    r = len_t'(8);
      3'd6:    r = len_t'(12);
      3'd7:    r = len_t'(16);
      default: r = len_t'(code) + len_t'(2);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pio_timing_decode.sv
module pio_timing_decode
  import pio_timing_pkg::*;
(
  input  logic [TB_W-1:0] tbyte_i,
  output timing_t         tim_o
);

  logic [SU_W-1:0]  su_code;
  logic [HLD_W-1:0] hld_code;
  logic [ACT_W-1:0] act_code;

  assign su_code  = tbyte_i[SU_LSB  +: SU_W];
  assign hld_code = tbyte_i[HLD_LSB +: HLD_W];
  assign act_code = tbyte_i[ACT_LSB +: ACT_W];

  always_comb begin
    tim_o.setup  = su_clocks(su_code);
    tim_o.hold   = hld_clocks(hld_code);
    tim_o.active = act_clocks(act_code);
  end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_i,
  input  logic    write_i,
  input  timing_t tim_i,
  input  logic    iordy_en_i,
  input  logic    iordy_i,
  output phase_e  phase_d_o,
  output logic    last_d_o,
  output logic    wr_d_o
);

  localparam len_t ONE = len_t'(1);

  phase_e phase_q, phase_d;
  len_t   cnt_q, cnt_d;
  len_t   act_q, act_d;
  len_t   hold_q, hold_d;
  logic   wr_q, wr_d;
  logic   stall;

  // The pin only matters when the handshake is enabled.
  assign stall = iordy_en_i && !iordy_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    hold_d  = hold_q;
    wr_d    = wr_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_SETUP;
          cnt_d   = tim_i.setup - ONE;
          act_d   = tim_i.active;
          hold_d  = tim_i.hold;
          wr_d    = write_i;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACTIVE;
          cnt_d   = act_q - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_ACTIVE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - ONE;
        end else if (!stall) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_q - ONE;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      hold_q  <= hold_d;
      wr_q    <= wr_d;
    end
  end

  assign phase_d_o = phase_d;
  assign last_d_o  = (cnt_d == '0);
  assign wr_d_o    = wr_d;

endmodule

// File: rtl/pio_strobe_out.sv
module pio_strobe_out
  import pio_timing_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_d_i,
  input  logic   last_d_i,
  input  logic   wr_d_i,
  output logic   rd_strobe_o,
  output logic   wr_strobe_o,
  output logic   busy_o,
  output logic   done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_strobe_o <= 1'b0;
      wr_strobe_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      rd_strobe_o <= (phase_d_i == PH_ACTIVE) && !wr_d_i;
      wr_strobe_o <= (phase_d_i == PH_ACTIVE) &&  wr_d_i;
      busy_o      <= (phase_d_i != PH_IDLE);
      done_o      <= (phase_d_i == PH_HOLD) && last_d_i;
    end
  end

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timing_pkg::*;
#(
  parameter int N_PORTS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            write_i,
  input  logic            cmd_port_i,
  input  logic [TB_W-1:0] data_timing_i,
  input  logic [TB_W-1:0] cmd_timing_i,
  input  logic            iordy_en_i,
  input  logic            iordy_i,
  output logic            rd_strobe_o,
  output logic            wr_strobe_o,
  output logic            busy_o,
  output logic            done_o
);

  logic [TB_W-1:0] tbyte_w [N_PORTS];
  timing_t         tim_w   [N_PORTS];
  timing_t         tim_sel;
  phase_e          phase_d;
  logic            last_d;
  logic            wr_d;

  assign tbyte_w[0] = data_timing_i;
  assign tbyte_w[1] = cmd_timing_i;

  // One decoder per timing byte; the port flag picks the result.
  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_dec
    pio_timing_decode u_dec (
      .tbyte_i (tbyte_w[gi]),
      .tim_o   (tim_w[gi])
    );
  end

  assign tim_sel = cmd_port_i ? tim_w[1] : tim_w[0];

  pio_phase_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .write_i    (write_i),
    .tim_i      (tim_sel),
    .iordy_en_i (iordy_en_i),
    .iordy_i    (iordy_i),
    .phase_d_o  (phase_d),
    .last_d_o   (last_d),
    .wr_d_o     (wr_d)
  );

  pio_strobe_out u_out (
    .clk         (clk),
    .rst         (rst),
    .phase_d_i   (phase_d),
    .last_d_i    (last_d),
    .wr_d_i      (wr_d),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic iordy_en_i,
  input logic iordy_i,
  input logic rd_strobe_o,
  input logic wr_strobe_o,
  input logic busy_o,
  input logic done_o
);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe_o && wr_strobe_o));

  // R6
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_o || wr_strobe_o) |-> busy_o);

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

  // R7
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R8
  iordy_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_strobe_o || wr_strobe_o) && iordy_en_i && !iordy_i)
      |=> (rd_strobe_o || wr_strobe_o));

endmodule

bind pio_strobe_timer pio_strobe_timer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .iordy_en_i  (iordy_en_i),
  .iordy_i     (iordy_i),
  .rd_strobe_o (rd_strobe_o),
  .wr_strobe_o (wr_strobe_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/pio_strobe_timer_bench.sv
`timescale 1ns/1ps
module pio_strobe_timer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       write_i = 1'b0;
  logic       cmd_port_i = 1'b0;
  logic [7:0] data_timing_i = 8'h00;
  logic [7:0] cmd_timing_i = 8'h00;
  logic       iordy_en_i = 1'b0;
  logic       iordy_i = 1'b1;
  logic       rd_strobe_o, wr_strobe_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pio_strobe_timer u_pio_strobe_timer (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .write_i       (write_i),
    .cmd_port_i    (cmd_port_i),
    .data_timing_i (data_timing_i),
    .cmd_timing_i  (cmd_timing_i),
    .iordy_en_i    (iordy_en_i),
    .iordy_i       (iordy_i),
    .rd_strobe_o   (rd_strobe_o),
    .wr_strobe_o   (wr_strobe_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  // Expected phase lengths, from the requirement scales.
  function automatic int e_setup(input logic [7:0] b);
    return int'(b[7:6]) + 1;
  endfunction
  function automatic int e_hold(input logic [7:0] b);
    int c = int'(b[5:3]);
    if (c == 6) return 8;
    if (c == 7) return 12;
    return c + 1;
  endfunction
  function automatic int e_act(input logic [7:0] b);
    int c = int'(b[2:0]);
    if (c == 5) return 8;
    if (c == 6) return 12;
    if (c == 7) return 16;
    return c + 2;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One access. stall < 0: ready pin high. stall >= 0: pin low until the
  // strobe has lasted active+stall clocks. poke: second start mid-access
  // with every input changed.
  task automatic run_access(input logic [7:0] db, input logic [7:0] cb,
                            input logic wr, input logic cmd, input logic ien,
                            input int stall, input logic poke,
                            output int n_su, output int n_act, output int n_hld,
                            output int n_done, output int last_done, output int n_bad);
    int a_len;
    int cyc;
    a_len = e_act(cmd ? cb : db);
    n_su = 0; n_act = 0; n_hld = 0; n_done = 0; last_done = 0; n_bad = 0;
    @(negedge clk);
    data_timing_i = db; cmd_timing_i = cb; write_i = wr; cmd_port_i = cmd;
    iordy_en_i = ien; iordy_i = (stall >= 0) ? 1'b0 : 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 400) begin
      cyc++;
      if (rd_strobe_o || wr_strobe_o) begin
        n_act++;
        if (wr ? rd_strobe_o : wr_strobe_o) n_bad++;
      end else if (n_act == 0) n_su++;
      else n_hld++;
      last_done = done_o ? 1 : 0;
      if (done_o) n_done++;
      if (stall >= 0 && n_act == a_len + stall) iordy_i = 1'b1;
      if (poke && cyc == 1) begin
        start_i = 1'b1; write_i = ~wr; cmd_port_i = ~cmd;
        data_timing_i = 8'h00; cmd_timing_i = 8'h00;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    iordy_i = 1'b1;
  endtask

  task automatic check_access(input string tag, input logic [7:0] tb_sel,
                              input logic wr, input logic cmd, input logic ien,
                              input int stall, input logic poke);
    int su, ac, hl, dn, ld, bad;
    run_access(wr ? 8'h00 : 8'h00, 8'h00, wr, cmd, ien, -1, 1'b0, su, ac, hl, dn, ld, bad);
  endtask

  task automatic measure(input string tag, input logic [7:0] db, input logic [7:0] cb,
                         input logic wr, input logic cmd, input logic ien,
                         input int stall, input int extra, input logic poke);
    int su, ac, hl, dn, ld, bad;
    logic [7:0] sel;
    sel = cmd ? cb : db;
    run_access(db, cb, wr, cmd, ien, stall, poke, su, ac, hl, dn, ld, bad);
    chk({tag, " R2"}, "setup clocks", su, e_setup(sel));
    chk({tag, " R4"}, "strobe clocks", ac, e_act(sel) + extra);
    chk({tag, " R3"}, "hold clocks", hl, e_hold(sel));
    chk({tag, " R6"}, "wrong-direction strobe clocks", bad, 0);
    chk({tag, " R7"}, "done pulses", dn, 1);
    chk({tag, " R7"}, "done on last busy clock", ld, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    rst = 1'b0;
    chk("R1", "rd_strobe after reset", int'(rd_strobe_o), 0);
    chk("R1", "wr_strobe after reset", int'(wr_strobe_o), 0);
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "done after reset", int'(done_o), 0);
  endtask

  task automatic t_fastest;
    // R5: 0x00 on the data port is 1+2+1 clocks.
    int su, ac, hl, dn, ld, bad;
    run_access(8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, -1, 1'b0, su, ac, hl, dn, ld, bad);
    chk("R5", "total clocks for 0x00", su + ac + hl, 4);
  endtask

  task automatic t_sweep;
    logic [7:0] pats [8] = '{8'h00, 8'h49, 8'h92, 8'hDB, 8'h24, 8'h6D, 8'hB6, 8'hFF};
    for (int i = 0; i < 8; i++)
      measure("sweep", pats[i], 8'h00, logic'(i[0]), 1'b0, 1'b0, -1, 0, 1'b0);
  endtask

  task automatic t_port_select;
    // R5: command port uses the command byte.
    measure("R5 cmd-port", 8'hF5, 8'hDE, 1'b0, 1'b1, 1'b0, -1, 0, 1'b0);
    measure("R5 data-port", 8'hF5, 8'hDE, 1'b1, 1'b0, 1'b0, -1, 0, 1'b0);
  endtask

  task automatic t_iordy_stretch;
    // R8: 5 extra clocks while the pin is low.
    measure("R8 stretch", 8'h49, 8'h00, 1'b0, 1'b0, 1'b1, 5, 5, 1'b0);
    measure("R8 no-wait", 8'h92, 8'h00, 1'b1, 1'b0, 1'b1, 0, 0, 1'b0);
  endtask

  task automatic t_iordy_disabled;
    // R9: pin held low throughout, enable off, no stretch.
    measure("R9 ignored", 8'h49, 8'h00, 1'b1, 1'b0, 1'b0, 1000, 0, 1'b0);
  endtask

  task automatic t_busy_start;
    // R10 and R11: second start mid-access plus changed inputs.
    int idle_busy;
    measure("R10 R11 poke", 8'hDB, 8'hF5, 1'b0, 1'b0, 1'b0, -1, 0, 1'b1);
    idle_busy = 0;
    for (int k = 0; k < 4; k++) begin
      if (busy_o) idle_busy++;
      @(negedge clk);
    end
    chk("R10", "busy clocks after done", idle_busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_fastest();
    t_sweep();
    t_port_select();
    t_iordy_stretch();
    t_iordy_disabled();
    t_busy_start();
    summary();
    $finish;
  end

endmodule